// File: doc/BRIEF.md
# Vector structure load/store micro-op sequencer

This block takes one vector structure memory request, either the multi-register form or the single-lane form, and breaks it into a stream of micro-ops. Memory micro-ops move at most one 16-byte chunk each between memory and a bank of temporary vector registers. Marshalling micro-ops move data between that temporary bank and the architectural vector registers. An optional writeback micro-op updates the base register. The micro-ops leave one per accepted handshake on a valid/ready port. The block produces only the micro-op stream. It moves no data.

A request gives the direction, the form, an element size code, the data size in bits, the structure element count, the register count, the lane index, a replicate flag, a writeback flag, an offset register index, the first architectural vector register and the base register. The transfer size is computed when the request is accepted. A request whose size is illegal is rejected in that same cycle. The stream that follows depends only on the registered request.

Top module: `vec_struct_seq`

## Requirements
- R1: The transfer size is register count × data size / 8 in multi-register mode, and element count × (1 << element size code) in single-lane mode. The stream holds ceil(size/16) memory micro-ops (kind code 0). Memory micro-op i names temporary register TMP_BASE+i, uses byte offset 16·i and carries the base register index. It moves 16 bytes, except the last one, which moves size mod 16 bytes when that value is nonzero.
- R2: A load (store flag 0) emits all memory micro-ops first, then the writeback if it is enabled, then ceil(n/2) marshalling micro-ops (kind code 1). Here n is the register count in multi-register mode and the element count in single-lane mode. Marshalling micro-op i names architectural register vd+2i, modulo 32.
- R3: A store (store flag 1) emits its marshalling micro-ops first: two when the size exceeds 32 bytes, otherwise one. Marshalling micro-op i names temporary register TMP_BASE+2i and architectural register vd. The memory micro-ops follow, then the writeback if it is enabled.
- R4: When the offset index is not 31, the writeback micro-op has kind code 2 and carries that index (the register is added zero-extended). When the index is 31, it has kind code 3 and an immediate equal to the transfer size.
- R5: The final micro-op of a stream has last set and delayed-commit clear. Every earlier micro-op has delayed-commit set and last clear.
- R6: Every memory micro-op has the unaligned-allowed flag set and carries the request's element size code. The flag is clear on all other micro-ops.
- R7: A request whose size is 0 or greater than 64 is accepted and raises err_o for exactly one cycle, in the cycle after acceptance. It produces no micro-op.
- R8: In single-lane mode, every marshalling micro-op carries the lane index and the replicate flag. In multi-register mode both fields are 0.
- R9: uop_valid_o rises in the cycle after a request is accepted. A micro-op held with uop_ready_i low stays unchanged. req_ready_o stays low while a stream is in progress and returns high in the cycle after the last handshake.
- R10: While reset is held, uop_valid_o and err_o are low and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, so a request can be taken |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_lane_mode_i | input | 1 | 1 = single-lane form, 0 = multi-register form |
| req_esize_i | input | 2 | Element size code (element bytes = 1 << code) |
| req_dsize_i | input | 8 | Register data size in bits (multi-register form) |
| req_nelem_i | input | 3 | Structure element count |
| req_nregs_i | input | 3 | Register count (multi-register form) |
| req_lane_i | input | 4 | Lane index (single-lane form) |
| req_repl_i | input | 1 | Replicate flag (single-lane form) |
| req_wb_i | input | 1 | Base writeback enable |
| req_off_idx_i | input | 5 | Offset register index; 31 selects the immediate |
| req_vd_i | input | 5 | First architectural vector register |
| req_base_i | input | 5 | Base address register |
| err_o | output | 1 | One-cycle pulse when a request is rejected |
| uop_valid_o | output | 1 | Micro-op present |
| uop_ready_i | input | 1 | Micro-op taken |
| uop_kind_o | output | 2 | 0 memory, 1 marshal, 2 writeback by register, 3 writeback by immediate |
| uop_tmp_o | output | 5 | Temporary vector register |
| uop_arch_o | output | 5 | Architectural vector register (marshal) |
| uop_gpr_o | output | 5 | Base register |
| uop_off_idx_o | output | 5 | Offset register (writeback by register) |
| uop_offset_o | output | 7 | Byte offset from the base (memory) |
| uop_bytes_o | output | 5 | Access size in bytes (memory) |
| uop_imm_o | output | 7 | Writeback immediate |
| uop_esize_o | output | 2 | Element size code |
| uop_unaligned_o | output | 1 | Unaligned access allowed (memory) |
| uop_lane_o | output | 4 | Lane index (single-lane marshal) |
| uop_repl_o | output | 1 | Replicate flag (single-lane marshal) |
| uop_last_o | output | 1 | Final micro-op of the stream |
| uop_delay_o | output | 1 | Delayed commit |

## Verification
The bench targets the final chunk with a residual size. A wrong modulus there would show up as a 16-byte or zero-byte last access. It also runs a 32-byte store, where a strict-versus-inclusive comparison error would add a second marshalling micro-op. The marshal register numbering is pushed past register 31 to expose a design that saturates instead of wrapping. Writebacks are issued with index 31 and with ordinary indices; a bad decode there would swap the register and immediate forms or carry the wrong amount. Over-size and zero-size requests are sent to catch a design that leaks micro-ops after an error. A stalling consumer is also applied, which catches a design that advances or changes fields while ready is low.

// File: rtl/vss_pkg.sv
package vss_pkg;
  localparam int CHUNK_B = 16;
  localparam int MAX_B   = 64;
  localparam int TOT_W   = $clog2(MAX_B + 1);
  localparam int BYTE_W  = $clog2(CHUNK_B + 1);
  localparam int RES_W   = $clog2(CHUNK_B);
  localparam int CNT_W   = 4;
  localparam int REG_W   = 5;
  localparam logic [REG_W-1:0] IMM_SEL = '1;

  typedef enum logic [1:0] {
    K_MEM = 2'd0,
    K_MAR = 2'd1,
    K_WBR = 2'd2,
    K_WBI = 2'd3
  } kind_e;

  typedef struct packed {
    logic             store;
    logic             lane_mode;
    logic             wb;
    logic [1:0]       esize;
    logic [3:0]       lane;
    logic             repl;
    logic [REG_W-1:0] off_idx;
    logic [REG_W-1:0] vd;
    logic [REG_W-1:0] base;
  } ctx_t;
endpackage

// File: rtl/vss_sizer.sv
module vss_sizer
  import vss_pkg::*;
#(
  parameter int RAW_W = 12
) (
  input  logic             lane_mode_i,
  input  logic             store_i,
  input  logic             wb_i,
  input  logic [1:0]       esize_i,
  input  logic [7:0]       dsize_i,
  input  logic [2:0]       nelem_i,
  input  logic [2:0]       nregs_i,
  output logic [TOT_W-1:0] total_o,
  output logic [RES_W-1:0] res_o,
  output logic [CNT_W-1:0] n_mem_o,
  output logic [CNT_W-1:0] n_mar_o,
  output logic [CNT_W-1:0] n_all_o,
  output logic             bad_o
);
  localparam int SPLIT_B = 2 * CHUNK_B;

  logic [RAW_W-1:0] prod, raw;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    prod    = RAW_W'(nregs_i) * RAW_W'(dsize_i);
    raw     = lane_mode_i ? (RAW_W'(nelem_i) << esize_i) : (prod >> 3);
    bad_o   = (raw == '0) || (raw > RAW_W'(MAX_B));
    total_o = TOT_W'(raw);
    res_o   = RES_W'(raw % RAW_W'(CHUNK_B));
    n_mem_o = CNT_W'((raw + RAW_W'(CHUNK_B - 1)) / RAW_W'(CHUNK_B));
    cnt     = lane_mode_i ? CNT_W'(nelem_i) : CNT_W'(nregs_i);
    if (store_i) n_mar_o = (raw > RAW_W'(SPLIT_B)) ? CNT_W'(2) : CNT_W'(1);
    else         n_mar_o = (cnt + CNT_W'(1)) >> 1;
    n_all_o = n_mem_o + n_mar_o + CNT_W'(wb_i);
  end
endmodule

// File: rtl/vss_order.sv
module vss_order
  import vss_pkg::*;
#(
  parameter int TMP_BASE = 8
) (
  input  ctx_t             ctx_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [CNT_W-1:0] n_mem_i,
  input  logic [CNT_W-1:0] n_mar_i,
  input  logic [CNT_W-1:0] n_all_i,
  input  logic [TOT_W-1:0] total_i,
  input  logic [RES_W-1:0] res_i,
  output logic [1:0]       kind_o,
  output logic [REG_W-1:0] tmp_o,
  output logic [REG_W-1:0] arch_o,
  output logic [REG_W-1:0] off_idx_o,
  output logic [TOT_W-1:0] offset_o,
  output logic [BYTE_W-1:0] bytes_o,
  output logic [TOT_W-1:0] imm_o,
  output logic             unal_o,
  output logic [3:0]       lane_o,
  output logic             repl_o,
  output logic             last_o
);
  logic [CNT_W-1:0] mem_s, mar_s, mi, ai;
  logic in_mem, in_mar;

  always_comb begin
    if (ctx_i.store) begin
      mar_s = '0;
      mem_s = n_mar_i;
    end else begin
      mem_s = '0;
      mar_s = n_mem_i + CNT_W'(ctx_i.wb);
    end
    in_mem = (idx_i >= mem_s) && (idx_i < mem_s + n_mem_i);
    in_mar = (idx_i >= mar_s) && (idx_i < mar_s + n_mar_i);
    mi = idx_i - mem_s;
    ai = idx_i - mar_s;

    kind_o    = K_MEM;
    tmp_o     = '0;
    arch_o    = '0;
    off_idx_o = '0;
    offset_o  = '0;
    bytes_o   = '0;
    imm_o     = '0;
    unal_o    = 1'b0;
    lane_o    = '0;
    repl_o    = 1'b0;

    if (in_mem) begin
      kind_o   = K_MEM;
      tmp_o    = REG_W'(TMP_BASE) + REG_W'(mi);
      offset_o = TOT_W'(mi) * TOT_W'(CHUNK_B);
      bytes_o  = (mi == n_mem_i - CNT_W'(1) && res_i != '0) ? BYTE_W'(res_i)
                                                            : BYTE_W'(CHUNK_B);
      unal_o   = 1'b1;
    end else if (in_mar) begin
      kind_o = K_MAR;
      if (ctx_i.store) begin
        tmp_o  = REG_W'(TMP_BASE) + (REG_W'(ai) << 1);
        arch_o = ctx_i.vd;
      end else begin
        tmp_o  = REG_W'(TMP_BASE);
        arch_o = ctx_i.vd + (REG_W'(ai) << 1);
      end
      if (ctx_i.lane_mode) begin
        lane_o = ctx_i.lane;
        repl_o = ctx_i.repl;
      end
    end else if (ctx_i.off_idx == IMM_SEL) begin
      kind_o = K_WBI;
      imm_o  = total_i;
    end else begin
      kind_o    = K_WBR;
      off_idx_o = ctx_i.off_idx;
    end
    last_o = (idx_i == n_all_i - CNT_W'(1));
  end
endmodule

// File: rtl/vec_struct_seq.sv
module vec_struct_seq
  import vss_pkg::*;
#(
  parameter int TMP_BASE = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  logic       req_store_i,
  input  logic       req_lane_mode_i,
  input  logic [1:0] req_esize_i,
  input  logic [7:0] req_dsize_i,
  input  logic [2:0] req_nelem_i,
  input  logic [2:0] req_nregs_i,
  input  logic [3:0] req_lane_i,
  input  logic       req_repl_i,
  input  logic       req_wb_i,
  input  logic [4:0] req_off_idx_i,
  input  logic [4:0] req_vd_i,
  input  logic [4:0] req_base_i,
  output logic       err_o,
  output logic       uop_valid_o,
  input  logic       uop_ready_i,
  output logic [1:0] uop_kind_o,
  output logic [4:0] uop_tmp_o,
  output logic [4:0] uop_arch_o,
  output logic [4:0] uop_gpr_o,
  output logic [4:0] uop_off_idx_o,
  output logic [6:0] uop_offset_o,
  output logic [4:0] uop_bytes_o,
  output logic [6:0] uop_imm_o,
  output logic [1:0] uop_esize_o,
  output logic       uop_unaligned_o,
  output logic [3:0] uop_lane_o,
  output logic       uop_repl_o,
  output logic       uop_last_o,
  output logic       uop_delay_o
);
  logic             busy_q, err_q, acc, bad;
  logic [CNT_W-1:0] idx_q;
  ctx_t             ctx_q, ctx_d;
  logic [TOT_W-1:0] total_d, total_q;
  logic [RES_W-1:0] res_d, res_q;
  logic [CNT_W-1:0] n_mem_d, n_mem_q, n_mar_d, n_mar_q, n_all_d, n_all_q;
  logic             last;

  vss_sizer u_sizer (
    .lane_mode_i(req_lane_mode_i),
    .store_i    (req_store_i),
    .wb_i       (req_wb_i),
    .esize_i    (req_esize_i),
    .dsize_i    (req_dsize_i),
    .nelem_i    (req_nelem_i),
    .nregs_i    (req_nregs_i),
    .total_o    (total_d),
    .res_o      (res_d),
    .n_mem_o    (n_mem_d),
    .n_mar_o    (n_mar_d),
    .n_all_o    (n_all_d),
    .bad_o      (bad)
  );

  always_comb begin
    ctx_d.store     = req_store_i;
    ctx_d.lane_mode = req_lane_mode_i;
    ctx_d.wb        = req_wb_i;
    ctx_d.esize     = req_esize_i;
    ctx_d.lane      = req_lane_i;
    ctx_d.repl      = req_repl_i;
    ctx_d.off_idx   = req_off_idx_i;
    ctx_d.vd        = req_vd_i;
    ctx_d.base      = req_base_i;
  end

  assign req_ready_o = !busy_q;
  assign acc         = req_valid_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      idx_q   <= '0;
      ctx_q   <= '0;
      total_q <= '0;
      res_q   <= '0;
      n_mem_q <= '0;
      n_mar_q <= '0;
      n_all_q <= '0;
    end else begin
      err_q <= acc && bad;
      if (acc && !bad) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        ctx_q   <= ctx_d;
        total_q <= total_d;
        res_q   <= res_d;
        n_mem_q <= n_mem_d;
        n_mar_q <= n_mar_d;
        n_all_q <= n_all_d;
      end else if (busy_q && uop_ready_i) begin
        if (last) busy_q <= 1'b0;
        else      idx_q  <= idx_q + CNT_W'(1);
      end
    end
  end

  vss_order #(.TMP_BASE(TMP_BASE)) u_order (
    .ctx_i    (ctx_q),
    .idx_i    (idx_q),
    .n_mem_i  (n_mem_q),
    .n_mar_i  (n_mar_q),
    .n_all_i  (n_all_q),
    .total_i  (total_q),
    .res_i    (res_q),
    .kind_o   (uop_kind_o),
    .tmp_o    (uop_tmp_o),
    .arch_o   (uop_arch_o),
    .off_idx_o(uop_off_idx_o),
    .offset_o (uop_offset_o),
    .bytes_o  (uop_bytes_o),
    .imm_o    (uop_imm_o),
    .unal_o   (uop_unaligned_o),
    .lane_o   (uop_lane_o),
    .repl_o   (uop_repl_o),
    .last_o   (last)
  );

  assign err_o       = err_q;
  assign uop_valid_o = busy_q;
  assign uop_gpr_o   = ctx_q.base;
  assign uop_esize_o = ctx_q.esize;
  assign uop_last_o  = last;
  assign uop_delay_o = !last;
endmodule

// File: rtl/vss_chk.sv
module vss_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       err_o,
  input logic       uop_valid_o,
  input logic       uop_ready_i,
  input logic [1:0] uop_kind_o,
  input logic [4:0] uop_tmp_o,
  input logic [4:0] uop_bytes_o,
  input logic       uop_unaligned_o,
  input logic [6:0] uop_imm_o,
  input logic       uop_last_o
);
  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !uop_ready_i |=> uop_valid_o && $stable(uop_kind_o)
      && $stable(uop_tmp_o) && $stable(uop_last_o)); // R9
  AST_END_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_ready_i && uop_last_o |=> !uop_valid_o); // R5
  AST_START_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uop_valid_o) |-> $past(req_valid_i)); // R9
  AST_ERR_NO_UOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !uop_valid_o); // R7
  AST_MEM_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_kind_o == 2'd0 |->
      uop_bytes_o != 5'd0 && uop_bytes_o <= 5'd16 && uop_unaligned_o); // R6
  AST_WB_IMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_kind_o == 2'd3 |-> uop_imm_o != 7'd0 && uop_imm_o <= 7'd64); // R4
endmodule

bind vec_struct_seq vss_chk u_vss_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .err_o          (err_o),
  .uop_valid_o    (uop_valid_o),
  .uop_ready_i    (uop_ready_i),
  .uop_kind_o     (uop_kind_o),
  .uop_tmp_o      (uop_tmp_o),
  .uop_bytes_o    (uop_bytes_o),
  .uop_unaligned_o(uop_unaligned_o),
  .uop_imm_o      (uop_imm_o),
  .uop_last_o     (uop_last_o)
);

// File: tb/tb_vec_struct_seq.sv
module tb_vec_struct_seq;
  localparam int TMPB = 8;
  localparam int NV   = 9;

  typedef struct packed {
    logic       store;
    logic       lmode;
    logic [1:0] esz;
    logic [7:0] dsz;
    logic [2:0] nel;
    logic [2:0] nrg;
    logic [3:0] lane;
    logic       rep;
    logic       wb;
    logic [4:0] offi;
    logic [4:0] vd;
    logic [4:0] base;
    logic [3:0] cnt;
  } vec_t;

  typedef struct packed {
    logic [1:0] kind;
    logic [4:0] tmp;
    logic [4:0] arch;
    logic [4:0] offi;
    logic [6:0] offset;
    logic [4:0] bytes;
    logic [6:0] imm;
    logic       last;
  } exp_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 2'd2, 8'd128, 3'd0, 3'd4, 4'd0, 1'b0, 1'b1, 5'd31, 5'd4,  5'd3,  4'd7},
    '{1'b0, 1'b0, 2'd1, 8'd64,  3'd0, 3'd3, 4'd0, 1'b0, 1'b1, 5'd5,  5'd30, 5'd2,  4'd5},
    '{1'b1, 1'b0, 2'd0, 8'd128, 3'd0, 3'd3, 4'd0, 1'b0, 1'b0, 5'd31, 5'd2,  5'd1,  4'd5},
    '{1'b1, 1'b0, 2'd3, 8'd64,  3'd0, 3'd1, 4'd0, 1'b0, 1'b1, 5'd31, 5'd7,  5'd0,  4'd3},
    '{1'b0, 1'b1, 2'd3, 8'd0,   3'd4, 3'd0, 4'd1, 1'b0, 1'b0, 5'd31, 5'd10, 5'd4,  4'd4},
    '{1'b1, 1'b1, 2'd0, 8'd0,   3'd3, 3'd0, 4'd9, 1'b0, 1'b1, 5'd31, 5'd12, 5'd6,  4'd3},
    '{1'b0, 1'b1, 2'd2, 8'd0,   3'd1, 3'd0, 4'd3, 1'b1, 1'b0, 5'd31, 5'd14, 5'd8,  4'd2},
    '{1'b1, 1'b0, 2'd2, 8'd128, 3'd0, 3'd2, 4'd0, 1'b0, 1'b1, 5'd17, 5'd16, 5'd9,  4'd4},
    '{1'b0, 1'b0, 2'd3, 8'd64,  3'd0, 3'd1, 4'd0, 1'b0, 1'b0, 5'd31, 5'd20, 5'd31, 4'd2}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_store_i = 1'b0, req_lane_mode_i = 1'b0;
  logic [1:0] req_esize_i = '0;
  logic [7:0] req_dsize_i = '0;
  logic [2:0] req_nelem_i = '0, req_nregs_i = '0;
  logic [3:0] req_lane_i = '0;
  logic req_repl_i = 1'b0, req_wb_i = 1'b0;
  logic [4:0] req_off_idx_i = '0, req_vd_i = '0, req_base_i = '0;
  logic uop_ready_i = 1'b1;
  logic req_ready_o, err_o, uop_valid_o;
  logic [1:0] uop_kind_o, uop_esize_o;
  logic [4:0] uop_tmp_o, uop_arch_o, uop_gpr_o, uop_off_idx_o, uop_bytes_o;
  logic [6:0] uop_offset_o, uop_imm_o;
  logic uop_unaligned_o, uop_repl_o, uop_last_o, uop_delay_o;
  logic [3:0] uop_lane_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done_all = 1'b0;

  always #2ns clk = ~clk;

  vec_struct_seq dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_store_i(req_store_i), .req_lane_mode_i(req_lane_mode_i),
    .req_esize_i(req_esize_i), .req_dsize_i(req_dsize_i),
    .req_nelem_i(req_nelem_i), .req_nregs_i(req_nregs_i),
    .req_lane_i(req_lane_i), .req_repl_i(req_repl_i), .req_wb_i(req_wb_i),
    .req_off_idx_i(req_off_idx_i), .req_vd_i(req_vd_i), .req_base_i(req_base_i),
    .err_o(err_o), .uop_valid_o(uop_valid_o), .uop_ready_i(uop_ready_i),
    .uop_kind_o(uop_kind_o), .uop_tmp_o(uop_tmp_o), .uop_arch_o(uop_arch_o),
    .uop_gpr_o(uop_gpr_o), .uop_off_idx_o(uop_off_idx_o),
    .uop_offset_o(uop_offset_o), .uop_bytes_o(uop_bytes_o), .uop_imm_o(uop_imm_o),
    .uop_esize_o(uop_esize_o), .uop_unaligned_o(uop_unaligned_o),
    .uop_lane_o(uop_lane_o), .uop_repl_o(uop_repl_o),
    .uop_last_o(uop_last_o), .uop_delay_o(uop_delay_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input vec_t v, input int k);
    exp_t e;
    int tot, nm, rs, cnt, nmar, wbn, all, ms, as, mi, ai;
    e = '0;
    tot = v.lmode ? int'(v.nel) * (1 << v.esz) : int'(v.nrg) * int'(v.dsz) / 8;
    nm = (tot + 15) / 16;
    rs = tot % 16;
    cnt = v.lmode ? int'(v.nel) : int'(v.nrg);
    nmar = v.store ? ((tot > 32) ? 2 : 1) : (cnt + 1) / 2;
    wbn = int'(v.wb);
    all = nm + nmar + wbn;
    if (v.store) begin as = 0; ms = nmar; end
    else begin ms = 0; as = nm + wbn; end
    mi = k - ms;
    ai = k - as;
    if (k >= ms && k < ms + nm) begin
      e.kind = 2'd0;
      e.tmp = 5'(TMPB + mi);
      e.offset = 7'(16 * mi);
      e.bytes = (mi == nm - 1 && rs != 0) ? 5'(rs) : 5'd16;
    end else if (k >= as && k < as + nmar) begin
      e.kind = 2'd1;
      e.tmp = v.store ? 5'(TMPB + 2 * ai) : 5'(TMPB);
      e.arch = v.store ? v.vd : 5'(int'(v.vd) + 2 * ai);
    end else if (v.offi == 5'd31) begin
      e.kind = 2'd3;
      e.imm = 7'(tot);
    end else begin
      e.kind = 2'd2;
      e.offi = v.offi;
    end
    e.last = (k == all - 1);
    return e;
  endfunction

  task automatic drive(input vec_t v);
    req_store_i = v.store; req_lane_mode_i = v.lmode; req_esize_i = v.esz;
    req_dsize_i = v.dsz; req_nelem_i = v.nel; req_nregs_i = v.nrg;
    req_lane_i = v.lane; req_repl_i = v.rep; req_wb_i = v.wb;
    req_off_idx_i = v.offi; req_vd_i = v.vd; req_base_i = v.base;
    req_valid_i = 1'b1;
  endtask

  task automatic run_vec(input vec_t v, input bit stall);
    int k, cyc;
    bit fin;
    exp_t e;
    string tg;
    drive(v);
    @(negedge clk);
    req_valid_i = 1'b0;
    k = 0; cyc = 0; fin = 1'b0;
    while (!fin && cyc < 64) begin
      uop_ready_i = stall ? cyc[0] : 1'b1;
      e = model(v, k);
      chk(uop_valid_o === 1'b1 && req_ready_o === 1'b0, "R9 busy",
          {uop_valid_o, req_ready_o}, 64'b10);
      tg = (e.kind == 2'd0) ? "R1 mem" : (e.kind == 2'd1) ? (v.store ? "R3 marshal" : "R2 marshal")
                                                          : "R4 writeback";
      chk({uop_kind_o, uop_tmp_o, uop_arch_o, uop_offset_o, uop_bytes_o, uop_imm_o,
           (e.kind == 2'd2) ? uop_off_idx_o : 5'd0, uop_gpr_o} ===
          {e.kind, e.tmp, e.arch, e.offset, e.bytes, e.imm, e.offi, v.base}, tg,
          {uop_kind_o, uop_tmp_o, uop_arch_o, uop_offset_o, uop_bytes_o, uop_imm_o},
          {e.kind, e.tmp, e.arch, e.offset, e.bytes, e.imm});
      chk(uop_last_o === e.last && uop_delay_o === !e.last, "R5 last/delay",
          {uop_last_o, uop_delay_o}, {e.last, !e.last});
      chk(uop_unaligned_o === (e.kind == 2'd0) && uop_esize_o === v.esz, "R6 unaligned/esize",
          {uop_unaligned_o, uop_esize_o}, {e.kind == 2'd0, v.esz});
      if (e.kind == 2'd1)
        chk({uop_lane_o, uop_repl_o} === (v.lmode ? {v.lane, v.rep} : 5'd0), "R8 lane/replicate",
            {uop_lane_o, uop_repl_o}, v.lmode ? {v.lane, v.rep} : 5'd0);
      if (uop_ready_i) begin
        if (uop_last_o === 1'b1) fin = 1'b1;
        k++;
      end
      @(negedge clk);
      cyc++;
    end
    uop_ready_i = 1'b1;
    chk(k == int'(v.cnt), v.store ? "R3 count" : "R2 count", 64'(k), 64'(v.cnt));
    chk(uop_valid_o === 1'b0 && req_ready_o === 1'b1, "R9 idle after last",
        {uop_valid_o, req_ready_o}, 64'b01);
  endtask

  task automatic run_bad(input vec_t v);
    drive(v);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(err_o === 1'b1 && uop_valid_o === 1'b0 && req_ready_o === 1'b1, "R7 reject",
        {err_o, uop_valid_o, req_ready_o}, 64'b101);
    @(negedge clk);
    chk(err_o === 1'b0 && uop_valid_o === 1'b0, "R7 single pulse",
        {err_o, uop_valid_o}, 64'b00);
  endtask

  initial begin
    vec_t b;
    repeat (3) @(negedge clk);
    chk(uop_valid_o === 1'b0 && err_o === 1'b0 && req_ready_o === 1'b1, "R10 reset",
        {uop_valid_o, err_o, req_ready_o}, 64'b001);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);
    // stalling consumer (R9)
    run_vec(VEC[0], 1'b1);
    run_vec(VEC[2], 1'b1);
    run_vec(VEC[5], 1'b1);
    // zero size, multi-register (R7)
    b = VEC[0]; b.nrg = 3'd0;
    run_bad(b);
    // 68 bytes (R7)
    b = VEC[2]; b.dsz = 8'd136; b.nrg = 3'd4;
    run_bad(b);
    // zero size, single-lane (R7)
    b = VEC[4]; b.nel = 3'd0;
    run_bad(b);
    // still works after rejects
    run_vec(VEC[1], 1'b0);
    done_all = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800us;
    if (!done_all) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule